// File: doc/BRIEF.md
# LUT Trigger Evaluator

This block decides, one logic sample per clock, whether a programmable trigger condition has been met on a 16-channel input. It does not use fixed comparators. The conditions live in small truth tables that a host loads through a narrow configuration port.

The channels are cut into four nibble-wide groups. Each group's value addresses one bit of a 16-bit table. A bank of four such tables forms a condition. A bank reports a hit when all four of its looked-up bits are set.

There are three banks:
- The value/mask bank matches a level pattern.
- Two edge banks are each programmed to follow one channel.

A 16-entry glue table turns the previous and current outputs of the two edge banks into an edge event. The glue table can express a rise, a fall, or an OR of both units.

A separate fast mode bypasses all tables. In fast mode the block watches a single pin among channels 0 to 7 for a rising or falling edge.

A control state machine sequences the block:
- IDLE accepts loads.
- LOAD covers a table-load sequence in progress.
- ARMED evaluates the condition.
- FIRED holds after the trigger until the host releases the arm input.

The transitions are:
- IDLE→LOAD on a table-step write.
- LOAD→IDLE on the parameter write.
- IDLE→ARMED when arm is high and no table step is written.
- ARMED→FIRED on a qualifying sample.
- ARMED→IDLE and FIRED→IDLE when arm is low.

Top module: `lut_trigger_eval`

## Requirements
- R1: After reset the trigger output is 0, the state is IDLE, every table bit is 0 (so the value/mask bank never hits) and all parameter fields are 0.
- R2: The table of group g (g = 0..3) is addressed by sample bits [4g+3:4g]. The value/mask bank hits only when the addressed bit is set in all four groups. A bit j of a value/mask entry is set unless a masked channel of that group disagrees between bit position (channel − 4g) of j and the wanted value.
- R3: A write with cfg_code = 0x30 | i stores step i. The step writes bit i of every table, with this layout:
  - cfg_data[3:0] go to value/mask groups 0..3.
  - cfg_data[7:4] go to edge unit 0 groups 0..3.
  - cfg_data[11:8] go to edge unit 1 groups 0..3.
  - cfg_data[12] goes to glue entry i.
- R4: A write with cfg_code = 0x40 loads the parameters from cfg_data:
  - [2:0] is the fast pin.
  - [3] selects a falling edge in fast mode.
  - [4] enables fast mode.
  - [5] enables the edge units.
- R5: Each edge unit's output is the AND of its four looked-up bits. The glue index carries unit n's previous-sample output in bit 2n and its current output in bit 2n+1.
- R6: Outside fast mode, with edges disabled the trigger condition is the value/mask hit alone. With edges enabled it is the value/mask hit ANDed with the addressed glue entry.
- R7: In fast mode the condition is a 0→1 change of the selected pin between consecutive samples, or a 1→0 change when the falling bit is set. The tables are ignored.
- R8: The trigger output rises in the cycle after the clock edge that sampled the qualifying input, and lasts exactly one cycle. No further trigger occurs until the block is re-armed.
- R9: Table-step and parameter writes have no effect while the state is ARMED or FIRED.
- R10: The arm input starts evaluation only from IDLE and is ignored during LOAD. Arm low in ARMED returns to IDLE and suppresses a trigger in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one sample per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Level request to evaluate the trigger condition |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_code | input | 8 | Write select: 0x30..0x3F table step, 0x40 parameters |
| cfg_data | input | 13 | Table-step bits or parameter fields |
| sample | input | 16 | Logic sample for the current cycle |
| trig | output | 1 | Registered one-cycle trigger pulse |

## Verification
A rejected configuration write and a trigger hit can fall in the same cycle. The bench provokes this by issuing table-step writes while armed, with channel 0 toggling underneath: had the writes been taken, fast mode on pin 0 would fire at the next edge. It then places a write on the exact cycle a qualifying rising edge arrives. The pulse must still appear at the expected cycle, and later samples must behave as if the writes never happened. A disarm coinciding with a qualifying sample is judged the same way: the pulse must not appear.

// File: rtl/lte_pkg.sv
package lte_pkg;

    localparam int EDGE_UNITS = 2;

    localparam logic [3:0] CODE_STEP_HI = 4'h3;
    localparam logic [7:0] CODE_PARAM   = 8'h40;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_ARMED,
        ST_FIRED
    } ctl_state_t;

    typedef struct packed {
        logic       edge_en;
        logic       fast;
        logic       falling;
        logic [2:0] pin;
    } prm_t;

    localparam int PRM_W = $bits(prm_t);

endpackage

// File: rtl/lut_bank.sv
module lut_bank #(
    parameter int CHANNELS = 16,
    parameter int GROUP_W  = 4,
    localparam int GROUPS  = CHANNELS / GROUP_W,
    localparam int ENTRIES = 1 << GROUP_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [GROUP_W-1:0]  wr_idx,
    input  logic [GROUPS-1:0]   wr_bits,
    input  logic [CHANNELS-1:0] sample,
    output logic                hit
);

    logic [ENTRIES-1:0] tab [GROUPS];
    logic [GROUPS-1:0]  grp_hit;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tab[g] <= '0;
            end else if (wr_en) begin
                tab[g][wr_idx] <= wr_bits[g];
            end
        end

        assign grp_hit[g] = tab[g][sample[g*GROUP_W +: GROUP_W]];
    end

    assign hit = &grp_hit;

endmodule

// File: rtl/trig_ctrl.sv
module trig_ctrl
    import lte_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm,
    input  logic       step_req,
    input  logic       param_req,
    input  logic       cond,
    output ctl_state_t st,
    output logic       tab_we,
    output logic       prm_we,
    output logic       fire
);

    ctl_state_t st_d;

    always_comb begin
        st_d = st;
        unique case (st)
            ST_IDLE: begin
                if (step_req) begin
                    st_d = ST_LOAD;
                end else if (arm) begin
                    st_d = ST_ARMED;
                end
            end
            ST_LOAD: begin
                if (param_req) begin
                    st_d = ST_IDLE;
                end
            end
            ST_ARMED: begin
                if (!arm) begin
                    st_d = ST_IDLE;
                end else if (cond) begin
                    st_d = ST_FIRED;
                end
            end
            ST_FIRED: begin
                if (!arm) begin
                    st_d = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_d;
        end
    end

    always_comb begin
        tab_we = 1'b0;
        prm_we = 1'b0;
        fire   = 1'b0;
        unique case (st)
            ST_IDLE, ST_LOAD: begin
                tab_we = step_req;
                prm_we = param_req;
            end
            ST_ARMED: begin
                fire = arm & cond;
            end
            ST_FIRED: begin
                fire = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lut_trigger_eval.sv
module lut_trigger_eval
    import lte_pkg::*;
#(
    parameter int CHANNELS = 16,
    parameter int GROUP_W  = 4,
    localparam int GROUPS  = CHANNELS / GROUP_W,
    localparam int BANKS   = 1 + EDGE_UNITS,
    localparam int LOAD_W  = GROUPS * BANKS + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                arm,
    input  logic                cfg_we,
    input  logic [7:0]          cfg_code,
    input  logic [LOAD_W-1:0]   cfg_data,
    input  logic [CHANNELS-1:0] sample,
    output logic                trig
);

    localparam int GLUE_W = 2 * EDGE_UNITS;
    localparam int GLUE_N = 1 << GLUE_W;

    ctl_state_t            st_q;
    prm_t                  prm_q;
    logic                  step_req, param_req;
    logic                  tab_we, prm_we, fire, cond;
    logic [BANKS-1:0]      bank_hit;
    logic [EDGE_UNITS-1:0] e_prev;
    logic [GLUE_N-1:0]     glue_q;
    logic [GLUE_W-1:0]     glue_idx;
    logic [CHANNELS-1:0]   prev_s;
    logic                  pin_now, pin_old, fast_hit, lut_hit;

    assign step_req  = cfg_we && (cfg_code[7:4] == CODE_STEP_HI);
    assign param_req = cfg_we && (cfg_code == CODE_PARAM);

    // bank 0: value/mask, banks 1..EDGE_UNITS: edge units
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        lut_bank #(
            .CHANNELS (CHANNELS),
            .GROUP_W  (GROUP_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (tab_we),
            .wr_idx  (cfg_code[GROUP_W-1:0]),
            .wr_bits (cfg_data[b*GROUPS +: GROUPS]),
            .sample  (sample),
            .hit     (bank_hit[b])
        );
    end

    for (genvar n = 0; n < EDGE_UNITS; n++) begin : g_gidx
        assign glue_idx[2*n]   = e_prev[n];
        assign glue_idx[2*n+1] = bank_hit[n+1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glue_q <= '0;
            prm_q  <= '0;
            e_prev <= '0;
            prev_s <= '0;
            trig   <= 1'b0;
        end else begin
            if (tab_we) begin
                glue_q[cfg_code[GLUE_W-1:0]] <= cfg_data[LOAD_W-1];
            end
            if (prm_we) begin
                prm_q <= prm_t'(cfg_data[PRM_W-1:0]);
            end
            e_prev <= bank_hit[EDGE_UNITS:1];
            prev_s <= sample;
            trig   <= fire;
        end
    end

    assign pin_now  = sample[prm_q.pin];
    assign pin_old  = prev_s[prm_q.pin];
    assign fast_hit = prm_q.falling ? (pin_old & ~pin_now) : (~pin_old & pin_now);
    assign lut_hit  = bank_hit[0] & (prm_q.edge_en ? glue_q[glue_idx] : 1'b1);
    assign cond     = prm_q.fast ? fast_hit : lut_hit;

    trig_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .step_req  (step_req),
        .param_req (param_req),
        .cond      (cond),
        .st        (st_q),
        .tab_we    (tab_we),
        .prm_we    (prm_we),
        .fire      (fire)
    );

endmodule

// File: rtl/trig_eval_chk.sv
module trig_eval_chk
    import lte_pkg::*;
#(
    parameter int CHANNELS = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                arm,
    input logic [CHANNELS-1:0] sample,
    input logic                trig,
    input ctl_state_t          st,
    input prm_t                prm,
    input logic                vm_hit
);

    logic [CHANNELS-1:0] s1, s2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= '0;
            s2 <= '0;
        end else begin
            s1 <= sample;
            s2 <= s1;
        end
    end

    p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !trig);

    p_armed_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> ($past(arm) && $past(st) == ST_ARMED));

    p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ARMED || st == ST_FIRED) |=> $stable(prm));

    p_fast_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && prm.fast && !prm.falling) |-> (s1[prm.pin] && !s2[prm.pin]));

    p_fast_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && prm.fast && prm.falling) |-> (!s1[prm.pin] && s2[prm.pin]));

    p_vm_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !prm.fast) |-> $past(vm_hit));

endmodule

bind lut_trigger_eval trig_eval_chk #(.CHANNELS(CHANNELS)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (arm),
    .sample (sample),
    .trig   (trig),
    .st     (st_q),
    .prm    (prm_q),
    .vm_hit (bank_hit[0])
);

// File: tb/test_lut_trigger_eval.sv
`timescale 1ns/1ps
module test_lut_trigger_eval;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_code = '0;
    logic [12:0] cfg_data = '0;
    logic [15:0] sample = '0;
    logic        trig;

    int vectors = 0;
    int errs = 0;
    bit done = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    lut_trigger_eval i_lut_trigger_eval (
        .clk(clk), .rst_n(rst_n), .arm(arm), .cfg_we(cfg_we),
        .cfg_code(cfg_code), .cfg_data(cfg_data), .sample(sample), .trig(trig)
    );

    // behavioural reference model
    int               m_st;   // 0 idle, 1 load, 2 armed, 3 fired
    logic [3:0][15:0] m_vm, m_e0, m_e1;
    logic [15:0]      m_glue;
    logic [5:0]       m_prm;
    logic [15:0]      m_prev;
    logic             m_e0p, m_e1p, m_trig;

    function automatic bit tab_hit(logic [3:0][15:0] t, logic [15:0] s);
        bit r = 1;
        for (int g = 0; g < 4; g++) if (!t[g][s[4*g +: 4]]) r = 0;
        return r;
    endfunction

    function automatic logic [15:0] lut_word(logic [15:0] v, logic [15:0] m, int g);
        logic [15:0] w = '1;
        for (int j = 0; j < 16; j++)
            for (int k = 0; k < 4; k++)
                if (m[4*g+k] && (((j >> k) & 1) != int'(v[4*g+k]))) w[j] = 1'b0;
        return w;
    endfunction

    task automatic model_update();
        bit vmh, e0c, e1c, cond, cur, pv, step, par, wr_ok;
        int gi, pin, i;
        if (!rst_n) begin
            m_st = 0; m_vm = '0; m_e0 = '0; m_e1 = '0; m_glue = '0; m_prm = '0;
            m_prev = '0; m_e0p = 0; m_e1p = 0; m_trig = 0;
            return;
        end
        vmh = tab_hit(m_vm, sample);
        e0c = tab_hit(m_e0, sample);
        e1c = tab_hit(m_e1, sample);
        gi  = int'(m_e0p) + 2*int'(e0c) + 4*int'(m_e1p) + 8*int'(e1c);
        pin = int'(m_prm[2:0]);
        cur = sample[pin];
        pv  = m_prev[pin];
        if (m_prm[4]) cond = m_prm[3] ? (pv && !cur) : (!pv && cur);
        else          cond = vmh && (m_prm[5] ? m_glue[gi] : 1'b1);
        step  = cfg_we && (cfg_code[7:4] == 4'h3);
        par   = cfg_we && (cfg_code == 8'h40);
        wr_ok = (m_st < 2);
        m_trig = (m_st == 2) && arm && cond;
        if (wr_ok && step) begin
            i = int'(cfg_code[3:0]);
            for (int g = 0; g < 4; g++) begin
                m_vm[g][i] = cfg_data[g];
                m_e0[g][i] = cfg_data[4+g];
                m_e1[g][i] = cfg_data[8+g];
            end
            m_glue[i] = cfg_data[12];
        end
        if (wr_ok && par) m_prm = cfg_data[5:0];
        case (m_st)
            0: if (step) m_st = 1; else if (arm) m_st = 2;
            1: if (par) m_st = 0;
            2: if (!arm) m_st = 0; else if (cond) m_st = 3;
            default: if (!arm) m_st = 0;
        endcase
        m_prev = sample;
        m_e0p = e0c;
        m_e1p = e1c;
    endtask

    task automatic cycle();
        @(posedge clk);
        model_update();
        @(negedge clk);
        vectors++;
        if (trig !== m_trig) begin
            errs++;
            $display("FAIL %s (model): trig=%0b expected %0b", cur_req, trig, m_trig);
        end
    endtask

    task automatic chk(logic exp, string req);
        vectors++;
        if (trig !== exp) begin
            errs++;
            $display("FAIL %s: trig=%0b expected %0b", req, trig, exp);
        end
    endtask

    task automatic load_cfg(logic [3:0][15:0] vm, logic [3:0][15:0] e0,
                            logic [3:0][15:0] e1, logic [15:0] gl, logic [5:0] p);
        for (int i = 0; i < 16; i++) begin
            logic [12:0] d;
            for (int g = 0; g < 4; g++) begin
                d[g] = vm[g][i]; d[4+g] = e0[g][i]; d[8+g] = e1[g][i];
            end
            d[12] = gl[i];
            cfg_we = 1; cfg_code = 8'h30 | 8'(i); cfg_data = d;
            cycle();
        end
        cfg_we = 1; cfg_code = 8'h40; cfg_data = 13'(p);
        cycle();
        cfg_we = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end

    initial begin
        logic [3:0][15:0] vm, e0, e1, z;
        logic [15:0] gl;
        z = '0;
        @(negedge clk);
        cur_req = "R1";
        repeat (3) cycle();
        rst_n = 1;
        cycle();
        chk(0, "R1 reset");
        // R1: cleared tables never hit even when armed
        arm = 1;
        for (int k = 0; k < 5; k++) begin
            sample = 16'(k * 16'h3579);
            cycle();
            chk(0, "R1 empty tables");
        end
        arm = 0; cycle();

        // R2 / R3: value/mask ch5=1, ch12=0
        cur_req = "R3";
        for (int g = 0; g < 4; g++) vm[g] = lut_word(16'h0020, 16'h1020, g);
        load_cfg(vm, z, z, 16'h0000, 6'b000000);
        cur_req = "R2";
        arm = 1; sample = 16'h0000; cycle();
        sample = 16'h0020; cycle(); chk(1, "R2 value match");
        cycle(); chk(0, "R8 single pulse");
        cycle(); chk(0, "R8 no refire while held");
        arm = 0; cycle();
        arm = 1; sample = 16'h1020; cycle();
        cycle(); chk(0, "R2 ch12 mismatch");
        sample = 16'hEFFF; cycle(); chk(1, "R2 unmasked channels ignored");
        arm = 0; cycle();

        // R5 / R6: unit0 rising ch9, unit1 falling ch2, value ch0=1
        cur_req = "R5";
        for (int g = 0; g < 4; g++) begin
            vm[g] = lut_word(16'h0001, 16'h0001, g);
            e0[g] = lut_word(16'h0200, 16'h0200, g);
            e1[g] = lut_word(16'h0004, 16'h0004, g);
        end
        for (int i = 0; i < 16; i++)
            gl[i] = ((i & 3) == 2) || ((i & 12) == 4);
        load_cfg(vm, e0, e1, gl, 6'b100000);
        arm = 1; sample = 16'h0001; cycle();
        sample = 16'h0201; cycle(); chk(1, "R5 unit0 rising");
        arm = 0; cycle();
        arm = 1; cycle();
        cycle(); chk(0, "R5 steady level");
        sample = 16'h0005; cycle(); chk(0, "R5 unit1 rise not selected");
        sample = 16'h0001; cycle(); chk(1, "R5 unit1 falling");
        arm = 0; cycle();
        cur_req = "R6";
        arm = 1; sample = 16'h0000; cycle();
        sample = 16'h0200; cycle(); chk(0, "R6 edge without value match");

        // R9: writes while armed are ignored
        cur_req = "R9";
        cfg_we = 1; cfg_code = 8'h40; cfg_data = 13'h0010; sample = 16'h0001;
        cycle(); chk(0, "R9 param write armed");
        for (int i = 0; i < 16; i++) begin
            cfg_code = 8'h30 | 8'(i); cfg_data = '0;
            sample = (i % 2) ? 16'h0001 : 16'h0000;
            cycle(); chk(0, "R9 step write armed");
        end
        cfg_we = 0; sample = 16'h0001; cycle();
        cfg_we = 1; cfg_code = 8'h30; cfg_data = '0; sample = 16'h0201;
        cycle(); chk(1, "R9 tables kept, hit with write");
        cfg_we = 0; arm = 0; cycle();

        // R7 / R4: fast mode
        cur_req = "R7";
        load_cfg(z, z, z, 16'h0000, 6'b010011);
        arm = 1; sample = 16'h0000; cycle();
        sample = 16'h0008; cycle(); chk(1, "R7 pin3 rising");
        arm = 0; cycle();
        cur_req = "R4";
        cfg_we = 1; cfg_code = 8'h40; cfg_data = 13'b011110; cycle();
        cfg_we = 0; arm = 1; sample = 16'h0040; cycle();
        cycle(); chk(0, "R4 pin6 steady");
        sample = 16'h0000; cycle(); chk(1, "R7 pin6 falling");
        arm = 0; cycle();

        // R10: arm ignored in LOAD, disarm wins
        cur_req = "R10";
        cfg_we = 1; cfg_code = 8'h3F; cfg_data = '0; arm = 1; cycle();
        cfg_we = 0; sample = 16'h0040; cycle();
        sample = 16'h0000; cycle(); chk(0, "R10 arm ignored in LOAD");
        cfg_we = 1; cfg_code = 8'h40; cfg_data = 13'b011110; sample = 16'h0040; cycle();
        cfg_we = 0; cycle();
        sample = 16'h0000; cycle(); chk(1, "R10 armed after param write");
        arm = 0; cycle();
        arm = 1; sample = 16'h0040; cycle();
        arm = 0; sample = 16'h0000; cycle(); chk(0, "R10 disarm on hit cycle");
        cycle(); chk(0, "R10 still idle");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

endmodule